// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a shared on-chip scratchpad of 16 KB. It is split into 16 banks of 32-bit words, and successive words are interleaved across the banks. Each accepted request group carries up to 16 lane requests, one per lane. Each lane request has an enable, a word address, a write flag and write data. The block works out the bank of every lane. Lanes that target the same word are merged into one access, so a read shared by many lanes costs a single bank slot. Lanes that hit one bank at different words are spread over successive cycles.

While a group is being served, the block holds `stall` high and ignores new requests. When every lane is finished, the block pulses `done` and presents the read data of all enabled lanes at the same time. `conf_degree` reports how many issue cycles the last group needed. Compute lanes use it to count the cost of bank conflicts. Conflicts are only counted within one group, never across groups.

Top module: `scratchpad`

## Requirements
- R1: The word address selects bank `addr[3:0]` and row `addr[11:4]`. A word written by one group is returned unchanged by a later group that reads it, at any address from 0 to 4095.
- R2: A group whose enabled lanes all fall into different banks holds `stall` high for exactly one cycle, and `conf_degree` reads 1 afterwards. Odd linear strides such as 1 and 3 are in this class.
- R3: When every enabled lane reads the same word, the group takes one issue cycle and all lanes return that word.
- R4: The number of issue cycles D equals the largest count of distinct word addresses that fall into any one bank. Linear stride 2 gives D=2, stride 8 gives D=8 and stride 16 gives D=16.
- R5: A request is accepted when `req_valid` is high on a clock edge where `stall` is low. `stall` is high for exactly the D cycles that follow the acceptance edge. A request presented while `stall` is high is ignored and leaves memory unchanged.
- R6: `done` is high for the single cycle that starts D+1 clock edges after the acceptance edge, and `stall` is low in that cycle. At that point `rd_data` holds the results of the group. `rd_data` keeps these values until the next group starts to return data.
- R7: When several lanes of one group write the same word, the data of the highest-numbered writing lane is stored.
- R8: Every lane of a group, including a lane that writes, returns the content its word had before the group. This holds even when another lane of the same group writes that word.
- R9: Once `done` has been seen, `conf_degree` equals D of the completed group, and it changes only in a `done` cycle. A group with no enabled lane gives `done` one edge after acceptance and `conf_degree` 0.
- R10: A disabled lane accesses no memory, and its slot of `rd_data` keeps its previous value.
- R11: After reset, `stall`, `done` and `conf_degree` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request group is presented |
| req_lane_en | input | 16 | Per-lane enable |
| req_addr | input | 16x12 | Per-lane word address |
| req_we | input | 16 | Per-lane write flag |
| req_wdata | input | 16x32 | Per-lane write data |
| stall | output | 1 | Group in service; new requests ignored |
| done | output | 1 | One-cycle pulse: the read data of the group are valid |
| rd_data | output | 16x32 | Per-lane read data |
| conf_degree | output | 5 | Issue cycles used by the last completed group |

## Verification
The bench drives linear strides of 1 and 3, which should run without conflicts. It then drives strides 2, 8 and 16, which should cost 2, 8 and 16 cycles. These patterns separate a correct bank mapping and degree count from an off-by-one or a wrong modulus.

All-lanes-same-word reads and two-address groups split across one bank show whether broadcast merging is applied to equal words only. Duplicate writes, a mixed read/write to one word, and sparse lane enables expose wrong lane priority, write-before-read ordering and stray updates of disabled lanes. Pseudo-random groups confined to a small address window mix all of these cases. A cycle model checks `stall` and `done` on every clock.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_LANES = 16;
  localparam int unsigned SP_BANKS = 16;
  localparam int unsigned SP_DW    = 32;
  localparam int unsigned SP_WORDS = 4096;
endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int unsigned DW   = 32,
  parameter int unsigned ROWS = 256,
  localparam int unsigned RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [ROWS];

  // read-first: a read and write of the same row return the old word
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem_q[row] <= wdata;
      rdata <= mem_q[row];
    end
  end
endmodule

// File: rtl/sp_pick.sv
module sp_pick #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned NBANKS = 16,
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32,
  localparam int unsigned BW    = $clog2(NBANKS),
  localparam int unsigned RW    = AW - BW
) (
  input  logic [LANES-1:0]          pend,
  input  logic [LANES-1:0][AW-1:0]  addr,
  input  logic [LANES-1:0]          we,
  input  logic [LANES-1:0][DW-1:0]  wdata,
  output logic [NBANKS-1:0]         bk_en,
  output logic [NBANKS-1:0]         bk_we,
  output logic [NBANKS-1:0][RW-1:0] bk_row,
  output logic [NBANKS-1:0][DW-1:0] bk_wd,
  output logic [LANES-1:0]          serve
);
  logic [LANES-1:0] srv_bank [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic           hit;
    logic [AW-1:0]  win;
    logic [LANES-1:0] srv;
    logic           wr;
    logic [DW-1:0]  wd;

    always_comb begin
      hit = 1'b0;
      win = '0;
      // scan downward so the lowest pending lane of this bank ends up chosen
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pend[l] && (addr[l][BW-1:0] == BW'(b))) begin
          hit = 1'b1;
          win = addr[l];
        end
      end
      srv = '0;
      wr  = 1'b0;
      wd  = '0;
      // scan upward so the highest writing lane of the chosen word wins
      for (int l = 0; l < LANES; l++) begin
        if (hit && pend[l] && (addr[l] == win)) begin
          srv[l] = 1'b1;
          if (we[l]) begin
            wr = 1'b1;
            wd = wdata[l];
          end
        end
      end
    end

    assign bk_en[b]    = hit;
    assign bk_we[b]    = wr;
    assign bk_row[b]   = win[AW-1:BW];
    assign bk_wd[b]    = wd;
    assign srv_bank[b] = srv;
  end

  always_comb begin
    serve = '0;
    for (int b = 0; b < NBANKS; b++) serve = serve | srv_bank[b];
  end
endmodule

// File: rtl/scratchpad.sv
module scratchpad
  import sp_pkg::*;
#(
  parameter int unsigned LANES  = SP_LANES,
  parameter int unsigned NBANKS = SP_BANKS,
  parameter int unsigned DW     = SP_DW,
  parameter int unsigned WORDS  = SP_WORDS,
  localparam int unsigned AW    = $clog2(WORDS),
  localparam int unsigned BW    = $clog2(NBANKS),
  localparam int unsigned RW    = AW - BW,
  localparam int unsigned ROWS  = WORDS / NBANKS,
  localparam int unsigned DEGW  = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [LANES-1:0]          req_lane_en,
  input  logic [LANES-1:0][AW-1:0]  req_addr,
  input  logic [LANES-1:0]          req_we,
  input  logic [LANES-1:0][DW-1:0]  req_wdata,
  output logic                      stall,
  output logic                      done,
  output logic [LANES-1:0][DW-1:0]  rd_data,
  output logic [DEGW-1:0]           conf_degree
);
  logic rst_sn;

  sp_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_sn));

  // control state
  logic             busy_q, busy_d;
  logic             last_q, last_d;
  logic             done_q, done_d;
  logic [LANES-1:0] pend_q, pend_d;
  logic [LANES-1:0] srv_q, srv_d;
  logic [DEGW-1:0]  cnt_q, cnt_d;
  logic [DEGW-1:0]  deg_q, deg_d;
  // data state
  logic [LANES-1:0][AW-1:0] addr_q;
  logic [LANES-1:0]         we_q;
  logic [LANES-1:0][DW-1:0] wd_q;
  logic [LANES-1:0][DW-1:0] rd_q, rd_d;

  logic [NBANKS-1:0]         bk_en, bk_we;
  logic [NBANKS-1:0][RW-1:0] bk_row;
  logic [NBANKS-1:0][DW-1:0] bk_wd;
  logic [DW-1:0]             bk_rd [NBANKS];
  logic [LANES-1:0]          serve;
  logic                      accept;

  sp_pick #(.LANES(LANES), .NBANKS(NBANKS), .AW(AW), .DW(DW)) u_pick (
    .pend(pend_q), .addr(addr_q), .we(we_q), .wdata(wd_q),
    .bk_en(bk_en), .bk_we(bk_we), .bk_row(bk_row), .bk_wd(bk_wd),
    .serve(serve)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_ram
    sp_bank #(.DW(DW), .ROWS(ROWS)) u_bank (
      .clk(clk), .en(bk_en[b]), .we(bk_we[b]), .row(bk_row[b]),
      .wdata(bk_wd[b]), .rdata(bk_rd[b])
    );
  end

  assign accept = req_valid && !busy_q;

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    last_d = 1'b0;
    srv_d  = '0;
    cnt_d  = cnt_q;
    done_d = last_q;
    deg_d  = last_q ? cnt_q : deg_q;
    if (accept) begin
      pend_d = req_lane_en;
      busy_d = |req_lane_en;
      last_d = ~|req_lane_en;
      cnt_d  = '0;
    end else if (busy_q) begin
      pend_d = pend_q & ~serve;
      srv_d  = serve;
      cnt_d  = DEGW'(cnt_q + 1'b1);
      if ((pend_q & ~serve) == '0) begin
        busy_d = 1'b0;
        last_d = 1'b1;
      end
    end
  end

  always_comb begin
    rd_d = rd_q;
    for (int l = 0; l < LANES; l++) begin
      if (srv_q[l]) rd_d[l] = bk_rd[addr_q[l][BW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
      srv_q  <= '0;
      cnt_q  <= '0;
      deg_q  <= '0;
    end else begin
      busy_q <= busy_d;
      last_q <= last_d;
      done_q <= done_d;
      pend_q <= pend_d;
      srv_q  <= srv_d;
      cnt_q  <= cnt_d;
      deg_q  <= deg_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= req_addr;
      we_q   <= req_we;
      wd_q   <= req_wdata;
    end
    if (|srv_q) rd_q <= rd_d;
  end

  assign stall       = busy_q;
  assign done        = done_q;
  assign rd_data     = rd_q;
  assign conf_degree = deg_q;
endmodule

// File: rtl/sp_chk.sv
module sp_chk #(
  parameter int unsigned LANES = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEGW  = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     stall,
  input logic                     done,
  input logic [LANES-1:0][DW-1:0] rd_data,
  input logic [DEGW-1:0]          conf_degree
);
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (stall) run_q <= run_q + 8'd1;
    else            run_q <= '0;
  end

  // R5
  stall_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(req_valid));

  // R4
  stall_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 8'(LANES));

  // R6
  done_not_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall);

  // R9
  degree_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(conf_degree) |-> done);

  // R9
  degree_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conf_degree <= DEGW'(LANES));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> (done || stall || $past(stall)));
endmodule

bind scratchpad sp_chk #(.LANES(LANES), .DW(DW), .DEGW(DEGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .stall(stall),
  .done(done), .rd_data(rd_data), .conf_degree(conf_degree)
);

// File: tb/scratchpad_bench.sv
module scratchpad_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L    = 16;
  localparam int DW   = 32;
  localparam int AW   = 12;
  localparam int DEGW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [L-1:0]         req_lane_en;
  logic [L-1:0][AW-1:0] req_addr;
  logic [L-1:0]         req_we;
  logic [L-1:0][DW-1:0] req_wdata;
  logic stall, done;
  logic [L-1:0][DW-1:0] rd_data;
  logic [DEGW-1:0] conf_degree;

  always #(CLK_PERIOD/2) clk = ~clk;

  scratchpad u_scratchpad (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lane_en(req_lane_en),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .stall(stall), .done(done), .rd_data(rd_data), .conf_degree(conf_degree)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] model_mem [4096];
  logic [DW-1:0] exp_rd [L];
  bit            exp_ok [L];
  logic [L-1:0]  g_en, g_we;
  logic [AW-1:0] g_addr [L];
  logic [DW-1:0] g_wd [L];
  int unsigned   seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [DW-1:0] pat(input int a);
    return (32'(a) * 32'h0101_0101) ^ 32'hA5A5_0000;
  endfunction

  task automatic set_stride(input int base, input int stride, input bit wr);
    g_en = '1;
    g_we = wr ? '1 : '0;
    for (int l = 0; l < L; l++) begin
      g_addr[l] = AW'(base + stride * l);
      g_wd[l]   = pat(base + stride * l);
    end
  endtask

  // run one group: model, drive, compare stall/done on every clock
  task automatic run_group(input string req, input bit poke);
    int deg;
    deg = 0;
    for (int b = 0; b < 16; b++) begin
      int n;
      n = 0;
      for (int l = 0; l < L; l++) begin
        bit first;
        first = g_en[l] && (g_addr[l][3:0] == 4'(b));
        for (int m = 0; m < l; m++)
          if (g_en[m] && g_addr[m] == g_addr[l]) first = 0;
        if (first) n++;
      end
      if (n > deg) deg = n;
    end
    for (int l = 0; l < L; l++)
      if (g_en[l]) begin exp_rd[l] = model_mem[g_addr[l]]; exp_ok[l] = 1; end
    for (int l = 0; l < L; l++)
      if (g_en[l] && g_we[l]) model_mem[g_addr[l]] = g_wd[l];

    @(negedge clk);
    check(stall == 1'b0, "R5", "stall before request", 32'(stall), 0);
    req_valid   = 1'b1;
    req_lane_en = g_en;
    req_we      = g_we;
    for (int l = 0; l < L; l++) begin
      req_addr[l]  = g_addr[l];
      req_wdata[l] = g_wd[l];
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int j = 0; j <= deg + 1; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 1) req_valid = 1'b0;
      check(stall == (j < deg), "R5", $sformatf("%s stall j=%0d", req, j),
            32'(stall), 32'(j < deg));
      check(done == (j == deg + 1), "R6", $sformatf("%s done j=%0d", req, j),
            32'(done), 32'(j == deg + 1));
      if (j == 0 && poke && deg > 0) begin
        // ignored request during stall: write junk to word 70
        req_valid      = 1'b1;
        req_lane_en    = 16'h0001;
        req_we         = 16'h0001;
        req_addr[0]    = 12'd70;
        req_wdata[0]   = 32'hDEAD_BEEF;
      end
    end
    req_valid = 1'b0;
    check(conf_degree == DEGW'(deg), "R9", {req, " degree"}, 32'(conf_degree), 32'(deg));
    for (int l = 0; l < L; l++)
      if (exp_ok[l])
        check(rd_data[l] === exp_rd[l], req, $sformatf("rd lane %0d", l),
              rd_data[l], exp_rd[l]);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_lane_en = '0;
    req_we = '0;
    req_addr = '0;
    req_wdata = '0;
    for (int l = 0; l < L; l++) exp_ok[l] = 0;
    repeat (3) @(negedge clk);
    // R11
    check(stall == 1'b0 && done == 1'b0, "R11", "stall/done in reset",
          {30'd0, stall, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(conf_degree == 0, "R11", "degree after reset", 32'(conf_degree), 0);
    check(stall == 1'b0 && done == 1'b0, "R11", "stall/done after reset",
          {30'd0, stall, done}, 0);

    // R1: fill words 0..255 and top block
    for (int g = 0; g < 16; g++) begin
      set_stride(16 * g, 1, 1);
      run_group("R1", 0);
    end
    set_stride(4080, 1, 1);
    run_group("R1", 0);
    set_stride(4080, 1, 0);
    run_group("R1", 0);

    // R2: odd strides
    set_stride(5, 1, 0);  run_group("R2", 0);
    set_stride(2, 3, 0);  run_group("R2", 0);
    // R4: stride 2, 8, 16; R5 ignored request during stride 8
    set_stride(1, 2, 0);  run_group("R4", 0);
    set_stride(3, 8, 0);  run_group("R4", 1);
    set_stride(0, 16, 0); run_group("R4", 0);
    // R5: junk write to word 70 must not have landed
    set_stride(70, 1, 0); run_group("R5", 0);

    // R3: broadcast
    set_stride(37, 0, 0); run_group("R3", 0);
    // R4: two words in one bank split between lane halves
    set_stride(10, 0, 0);
    for (int l = 8; l < L; l++) g_addr[l] = 12'd26;
    run_group("R4", 0);

    // R7: all lanes write word 50
    set_stride(50, 0, 1);
    for (int l = 0; l < L; l++) g_wd[l] = 32'hC000_0000 + 32'(l);
    run_group("R7", 0);
    set_stride(50, 0, 0); run_group("R7", 0);

    // R8: lane 0 reads word 60, lane 3 writes it
    g_en = 16'h0009; g_we = 16'h0008;
    g_addr[0] = 12'd60; g_addr[3] = 12'd60; g_wd[3] = 32'h0BAD_F00D;
    run_group("R8", 0);
    set_stride(60, 1, 0); run_group("R8", 0);

    // R10: sparse enables, other lanes keep old data
    set_stride(100, 1, 0);
    g_en = 16'h0024;
    run_group("R10", 0);

    // R9: empty group
    g_en = '0;
    run_group("R9", 0);

    // mixed pseudo-random groups in a small window
    for (int g = 0; g < 40; g++) begin
      for (int l = 0; l < L; l++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        g_en[l]   = seed[30] | seed[29];
        g_we[l]   = seed[27];
        g_addr[l] = AW'(seed[23:18]);
        g_wd[l]   = seed;
      end
      run_group("R4", 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule